// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block carries out complete operations on a byte-wide parallel NOR flash for a host. The host gives an operation code, a 22-bit address and a data byte, then pulses a start strobe. The block issues each bus cycle the operation needs: the unlock writes, the command write, the data or sector write, and the reads. It then watches the flash until the embedded algorithm inside the flash has finished.

Each flash bus cycle holds chip enable and either write enable or output enable low for a programmable number of clocks. The address and write data stay stable for the whole strobe. Completion of a program or an erase is found by reading the target address in pairs until two reads agree. A status bit marks an internal failure in the flash. When that bit is set, the block makes one more pair of reads before it gives up. It then sends the reset command and reports an error. At the end of every operation, done is a one-clock pulse. The value of the most recent read stays available on a data output.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held low, busy, done and error are 0 and all three flash strobes (chip enable, output enable, write enable) are high.
- R2: The operation codes are 0 program, 1 sector erase, 2 identify and 3 read. Program, erase and identify each start with a write of 0xAA to address 0x5555, then a write of 0x55 to address 0x2AAA, then a write to 0x5555 of the command byte (0xA0 program, 0x80 erase, 0x90 identify).
- R3: Program follows its command byte with a write of the request data byte to the full 22-bit request address, and then polls for completion.
- R4: Sector erase follows 0x80 with a second 0xAA/0x55 unlock pair, then writes 0x30 to the request address, and then polls for completion.
- R5: Identify follows 0x90 with one read of the request address, keeps the value on rd_data, and then writes 0xF0 to 0x5555. It does not poll.
- R6: Read performs one read of the request address, makes no write, and puts the value on rd_data.
- R7: In every bus cycle, chip enable and exactly one of write enable or output enable go low together for cfg_wait+1 clocks, and the address does not change while they are low. The block drives the data bus only while write enable is low.
- R8: Polling reads the request address in pairs. When the two reads of a pair are equal, the operation ends without error. When they differ and bit 5 of the second read is 0, a new pair is read.
- R9: When a pair differs and bit 5 of its second read is 1, exactly one more pair is read. If that pair matches, the operation ends without error.
- R10: If that extra pair also differs, the block writes 0xF0 to 0x5555 and ends the operation with error high during the done pulse.
- R11: A start strobe that arrives while busy is high is ignored. It adds no bus cycle and no extra done pulse.
- R12: Busy rises on the clock after an accepted start. Done is a single-clock pulse that occurs while busy is high, and busy is low on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wait | input | 3 | Extra strobe clocks per bus cycle |
| req_start | input | 1 | Start strobe for an operation |
| req_op | input | 2 | Operation code |
| req_addr | input | 22 | Target byte address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end-of-operation pulse |
| error | output | 1 | Failure flag, valid with done |
| rd_data | output | 8 | Value of the most recent read |
| fl_addr | output | 22 | Flash address bus |
| fl_dq | inout | 8 | Flash data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The assertions check the bus-level rules on every clock. They cover the pairing of the strobes, the strobe length against cfg_wait, the stable address during a strobe, and the release of the data bus during reads. They also cover the handshake rules for start, busy, done and error. The scenarios in the bench are the only evidence for the order and content of the write cycles for each operation. They also show the number of poll reads as the flash stays busy for longer, the recovery after a status with bit 5 set, the reset-then-error path, and that a start during an operation is ignored.

// File: rtl/nor_seq_pkg.sv
`timescale 1ns/1ps
package nor_seq_pkg;
  localparam int BYTE_W = 8;
  localparam logic [15:0] UNLK1_ADDR = 16'h5555;
  localparam logic [15:0] UNLK2_ADDR = 16'h2AAA;
  localparam logic [7:0] UNLK1_DATA = 8'hAA;
  localparam logic [7:0] UNLK2_DATA = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam int FAIL_BIT = 5;

  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_ERASE = 2'd1, OP_IDENT = 2'd2, OP_READ = 2'd3} op_e;
  typedef enum logic [1:0] {AS_UNLK1, AS_UNLK2, AS_TARGET} asel_e;
  typedef enum logic [1:0] {NX_STEP, NX_POLL, NX_END} nxt_e;
  typedef enum logic [1:0] {PV_DONE, PV_AGAIN, PV_RECHECK, PV_FAIL} poll_e;

  typedef struct packed {
    logic              wr;
    asel_e             asel;
    logic              from_req;
    logic [BYTE_W-1:0] data;
    nxt_e              nxt;
  } step_t;

  // Bus cycle number idx of operation op, before the polling phase.
  function automatic step_t step_of(op_e op, logic [2:0] idx);
    step_t s;
    s.wr = 1'b1; s.asel = AS_UNLK1; s.from_req = 1'b0; s.data = UNLK1_DATA; s.nxt = NX_STEP;
    if (op == OP_READ) begin
      s.wr = 1'b0; s.asel = AS_TARGET; s.data = '0; s.nxt = NX_END;
    end else begin
      case (idx)
        3'd0: ;
        3'd1: begin s.asel = AS_UNLK2; s.data = UNLK2_DATA; end
        3'd2: s.data = (op == OP_PROG) ? CMD_PROG : (op == OP_ERASE) ? CMD_ERASE : CMD_IDENT;
        3'd3: begin
          if (op == OP_PROG) begin
            s.asel = AS_TARGET; s.from_req = 1'b1; s.nxt = NX_POLL;
          end else if (op == OP_IDENT) begin
            s.wr = 1'b0; s.asel = AS_TARGET; s.data = '0;
          end
        end
        3'd4: begin
          if (op == OP_IDENT) begin s.data = CMD_RESET; s.nxt = NX_END; end
          else begin s.asel = AS_UNLK2; s.data = UNLK2_DATA; end
        end
        default: begin s.asel = AS_TARGET; s.data = CMD_SECTOR; s.nxt = NX_POLL; end
      endcase
    end
    return s;
  endfunction

  // Outcome of one completed pair of poll reads.
  function automatic poll_e judge(logic [BYTE_W-1:0] first, logic [BYTE_W-1:0] second, logic rechk);
    if (first == second) return PV_DONE;
    if (rechk)           return PV_FAIL;
    if (second[FAIL_BIT]) return PV_RECHECK;
    return PV_AGAIN;
  endfunction
endpackage

// File: rtl/nor_bus_cycle.sv
`timescale 1ns/1ps
module nor_bus_cycle import nor_seq_pkg::*; #(
  parameter int ADDR_W = 22,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BYTE_W-1:0] wdata_in,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [BYTE_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              drive_o,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [BYTE_W-1:0] rdata,
  output logic              cyc_done
);
  typedef enum logic [1:0] {B_IDLE, B_ACT, B_GAP} bst_e;
  bst_e              st;
  logic [WAIT_W-1:0] cnt;
  logic              wr_q;
  logic              strobe;

  assign strobe   = (st == B_ACT);
  assign ce_n     = !strobe;
  assign we_n     = !(strobe && wr_q);
  assign oe_n     = !(strobe && !wr_q);
  assign drive_o  = strobe && wr_q;
  assign cyc_done = (st == B_GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= B_IDLE; cnt <= '0; wr_q <= 1'b0;
      addr_o <= '0; wdata_o <= '0; rdata <= '0;
    end else begin
      case (st)
        B_IDLE: if (start) begin
          addr_o <= addr_in; wdata_o <= wdata_in; wr_q <= is_wr;
          cnt <= cfg_wait; st <= B_ACT;
        end
        B_ACT: begin
          if (cnt == '0) begin
            if (!wr_q) rdata <= dq_in;
            st <= B_GAP;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_seq_ctrl.sv
`timescale 1ns/1ps
module nor_seq_ctrl import nor_seq_pkg::*; #(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_data,
  input  logic              cyc_done,
  input  logic [BYTE_W-1:0] cyc_rdata,
  output logic              cyc_start,
  output logic              cyc_wr,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [BYTE_W-1:0] cyc_wdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [BYTE_W-1:0] rd_data
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FINISH} st_e;
  st_e               st;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q, first_q;
  logic [2:0]        idx;
  logic              in_poll, second, recheck, abort;
  step_t             cur;
  poll_e             verdict;

  always_comb begin
    cur = step_of(op_q, idx);
    if (abort) begin
      cur.wr = 1'b1; cur.asel = AS_UNLK1; cur.from_req = 1'b0; cur.data = CMD_RESET; cur.nxt = NX_END;
    end else if (in_poll) begin
      cur.wr = 1'b0; cur.asel = AS_TARGET; cur.from_req = 1'b0; cur.data = '0; cur.nxt = NX_POLL;
    end
  end

  assign verdict   = judge(first_q, cyc_rdata, recheck);
  assign cyc_start = (st == S_ISSUE);
  assign cyc_wr    = cur.wr;
  assign cyc_wdata = cur.from_req ? data_q : cur.data;
  assign cyc_addr  = (cur.asel == AS_UNLK1) ? ADDR_W'(UNLK1_ADDR) :
                     (cur.asel == AS_UNLK2) ? ADDR_W'(UNLK2_ADDR) : addr_q;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FINISH);
  assign error     = done && abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_READ; addr_q <= '0; data_q <= '0; first_q <= '0;
      idx <= '0; in_poll <= 1'b0; second <= 1'b0; recheck <= 1'b0; abort <= 1'b0;
      rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_start) begin
          op_q <= op_e'(req_op); addr_q <= req_addr; data_q <= req_data;
          idx <= '0; in_poll <= 1'b0; second <= 1'b0; recheck <= 1'b0; abort <= 1'b0;
          st <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (cyc_done) begin
          if (!cur.wr) rd_data <= cyc_rdata;
          if (abort) st <= S_FINISH;
          else if (in_poll) begin
            if (!second) begin
              first_q <= cyc_rdata; second <= 1'b1; st <= S_ISSUE;
            end else begin
              second <= 1'b0;
              case (verdict)
                PV_DONE:    st <= S_FINISH;
                PV_RECHECK: begin recheck <= 1'b1; st <= S_ISSUE; end
                PV_FAIL:    begin abort <= 1'b1; st <= S_ISSUE; end
                default:    st <= S_ISSUE;
              endcase
            end
          end else begin
            case (cur.nxt)
              NX_POLL: begin in_poll <= 1'b1; st <= S_ISSUE; end
              NX_END:  st <= S_FINISH;
              default: begin idx <= idx + 1'b1; st <= S_ISSUE; end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
`timescale 1ns/1ps
module nor_cmd_seq import nor_seq_pkg::*; #(
  parameter int ADDR_W = 22,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_start,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] fl_addr,
  inout  wire  [BYTE_W-1:0] fl_dq,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);
  logic              cyc_start, cyc_wr, cyc_done, bus_drive;
  logic [ADDR_W-1:0] cyc_addr;
  logic [BYTE_W-1:0] cyc_wdata, cyc_rdata, bus_wdata;

  assign fl_dq = bus_drive ? bus_wdata : 'z;

  nor_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .cyc_done(cyc_done),
    .cyc_rdata(cyc_rdata), .cyc_start(cyc_start), .cyc_wr(cyc_wr),
    .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .busy(busy), .done(done),
    .error(error), .rd_data(rd_data)
  );

  nor_bus_cycle #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .is_wr(cyc_wr),
    .addr_in(cyc_addr), .wdata_in(cyc_wdata), .cfg_wait(cfg_wait),
    .dq_in(fl_dq), .addr_o(fl_addr), .wdata_o(bus_wdata), .drive_o(bus_drive),
    .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n), .rdata(cyc_rdata),
    .cyc_done(cyc_done)
  );
endmodule

// File: rtl/nor_cmd_seq_chk.sv
`timescale 1ns/1ps
module nor_cmd_seq_chk #(
  parameter int ADDR_W = 22,
  parameter int WAIT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WAIT_W-1:0] cfg_wait,
  input logic              req_start,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              fl_ce_n,
  input logic              fl_oe_n,
  input logic              fl_we_n,
  input logic              dq_drive
);
  logic [WAIT_W:0] lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || fl_ce_n) lowcnt <= '0;
    else                   lowcnt <= lowcnt + 1'b1;
  end

  a_r7_we_with_ce: assert property (@(posedge clk) disable iff (!rst_n) !fl_we_n |-> !fl_ce_n);
  a_r7_oe_with_ce: assert property (@(posedge clk) disable iff (!rst_n) !fl_oe_n |-> !fl_ce_n);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n) !fl_ce_n |-> (fl_we_n != fl_oe_n));
  a_r7_release:    assert property (@(posedge clk) disable iff (!rst_n) dq_drive |-> !fl_we_n);
  a_r7_addr_hold:  assert property (@(posedge clk) disable iff (!rst_n)
                     (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));
  a_r7_width:      assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(fl_ce_n) |-> (lowcnt == (WAIT_W+1)'(cfg_wait) + 1'b1));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r12_done_busy:  assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  a_r12_done_idle:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  a_r12_accept:     assert property (@(posedge clk) disable iff (!rst_n) (req_start && !busy) |=> busy);
  a_r10_err_done:   assert property (@(posedge clk) disable iff (!rst_n) error |-> done);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .req_start(req_start),
  .busy(busy), .done(done), .error(error), .fl_addr(fl_addr),
  .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .dq_drive(bus_drive)
);

// File: tb/test_nor_cmd_seq.sv
`timescale 1ns/1ps
module nor_flash_bfm (
  input  logic        clk,
  input  logic [21:0] a,
  inout  wire  [7:0]  dq,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  int          busy_len,
  input  bit          stat5,
  input  bit          stuck
);
  logic [7:0]  mem [0:63];
  logic [21:0] la;
  logic [7:0]  ld, rv;
  int          st, busy_cnt;
  bit          id_mode, tog;
  logic        p_we, p_oe;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 29 + 53);
    st = 0; busy_cnt = 0; id_mode = 0; tog = 0; p_we = 1; p_oe = 1; la = '0; ld = '0;
  end

  always_comb begin
    if (busy_cnt > 0)  rv = {~mem[a[5:0]][7], tog, stat5, 5'b0};
    else if (id_mode)  rv = a[0] ? 8'h4F : 8'h01;
    else               rv = mem[a[5:0]];
  end
  assign dq = (!ce_n && !oe_n) ? rv : 8'hzz;

  always @(negedge clk) begin
    if (p_we == 1'b0 && we_n == 1'b1) begin
      if (ld == 8'hF0) begin st = 0; id_mode = 0; busy_cnt = 0; end
      else case (st)
        0: st = (la == 22'h5555 && ld == 8'hAA) ? 1 : 0;
        1: st = (la == 22'h2AAA && ld == 8'h55) ? 2 : 0;
        2: begin
          st = 0;
          if (la == 22'h5555) begin
            if (ld == 8'hA0) st = 3;
            else if (ld == 8'h80) st = 4;
            else if (ld == 8'h90) id_mode = 1;
          end
        end
        3: begin mem[la[5:0]] = mem[la[5:0]] & ld; busy_cnt = busy_len; st = 0; end
        4: st = (la == 22'h5555 && ld == 8'hAA) ? 5 : 0;
        5: st = (la == 22'h2AAA && ld == 8'h55) ? 6 : 0;
        default: begin
          if (ld == 8'h30) begin
            for (int i = 0; i < 16; i++) mem[{la[5:4], 4'(i)}] = 8'hFF;
            busy_cnt = busy_len;
          end
          st = 0;
        end
      endcase
    end
    if (!we_n) begin la = a; ld = dq; end
    if (p_oe == 1'b0 && oe_n == 1'b1 && busy_cnt > 0) begin
      tog = ~tog;
      if (!stuck) busy_cnt = busy_cnt - 1;
    end
    p_we = we_n; p_oe = oe_n;
  end
endmodule

module test_nor_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_wait = 3'd0;
  logic        req_start = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        busy, done, error, fl_ce_n, fl_oe_n, fl_we_n;
  logic [7:0]  rd_data;
  logic [21:0] fl_addr;
  wire  [7:0]  fl_dq;
  int          busy_len = 1;
  bit          stat5 = 0, stuck = 0;

  int n_chk = 0, n_fail = 0;
  int log_n, rd_n, done_n, width_bad, exp_n;
  logic [21:0] log_a [0:15], exp_a [0:15];
  logic [7:0]  log_d [0:15], exp_d [0:15];
  logic [21:0] mon_a;
  logic [7:0]  mon_d;
  int          we_lo = 0, oe_lo = 0;
  logic        p_we = 1'b1, p_oe = 1'b1;
  logic [7:0]  mir [0:63];

  always #4 clk = ~clk;

  nor_cmd_seq i_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .req_start(req_start),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .busy(busy),
    .done(done), .error(error), .rd_data(rd_data), .fl_addr(fl_addr),
    .fl_dq(fl_dq), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  nor_flash_bfm i_flash (
    .clk(clk), .a(fl_addr), .dq(fl_dq), .ce_n(fl_ce_n), .oe_n(fl_oe_n),
    .we_n(fl_we_n), .busy_len(busy_len), .stat5(stat5), .stuck(stuck)
  );

  always @(negedge clk) begin
    if (!fl_we_n) begin mon_a = fl_addr; mon_d = fl_dq; we_lo++; end
    else if (p_we == 1'b0) begin
      if (log_n < 16) begin log_a[log_n] = mon_a; log_d[log_n] = mon_d; end
      log_n++;
      if (we_lo != int'(cfg_wait) + 1) width_bad++;
      we_lo = 0;
    end
    if (!fl_oe_n) oe_lo++;
    else if (p_oe == 1'b0) begin
      rd_n++;
      if (oe_lo != int'(cfg_wait) + 1) width_bad++;
      oe_lo = 0;
    end
    if (done) done_n++;
    p_we = fl_we_n; p_oe = fl_oe_n;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [21:0] a, input logic [7:0] d);
    exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic set_exp(input int op, input logic [21:0] a, input logic [7:0] d);
    exp_n = 0;
    if (op != 3) begin
      push(22'h5555, 8'hAA); push(22'h2AAA, 8'h55);
      push(22'h5555, op == 0 ? 8'hA0 : op == 1 ? 8'h80 : 8'h90);
      if (op == 0) push(a, d);
      if (op == 1) begin push(22'h5555, 8'hAA); push(22'h2AAA, 8'h55); push(a, 8'h30); end
      if (op == 2) push(22'h5555, 8'hF0);
    end
  endtask

  task automatic chk_seq(input string tag);
    bit ok;
    ok = (log_n == exp_n);
    for (int i = 0; i < exp_n && i < 16; i++)
      if (log_a[i] !== exp_a[i] || log_d[i] !== exp_d[i]) ok = 0;
    check(ok, tag, log_n, exp_n);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [21:0] ad, input logic [7:0] dt,
                        input bit intrude, output logic err, output logic [7:0] rv);
    bit seen;
    log_n = 0; rd_n = 0; done_n = 0; width_bad = 0; seen = 0; err = 0; rv = '0;
    @(negedge clk); req_op = op; req_addr = ad; req_data = dt; req_start = 1'b1;
    @(negedge clk); req_start = 1'b0;
    check(busy == 1'b1, "R12 busy after accepted start", busy, 1);
    for (int t = 0; t < 20000 && !seen; t++) begin
      @(negedge clk);
      if (intrude && t == 3) begin req_op = 2'd1; req_addr = 22'h00_0030; req_start = 1'b1; end
      if (intrude && t == 4) req_start = 1'b0;
      if (done) begin seen = 1; err = error; rv = rd_data; end
    end
    if (!seen) check(0, "R12 operation never finished", 0, 1);
    @(negedge clk);
    check(busy == 1'b0, "R12 idle after done", busy, 0);
    @(negedge clk); @(negedge clk);
    check(done_n == 1, "R12 single done pulse", done_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic err;
    logic [7:0] rv;
    logic [21:0] a;
    logic [7:0] d;
    for (int i = 0; i < 64; i++) mir[i] = 8'(i * 29 + 53);
    log_n = 0; rd_n = 0; done_n = 0; width_bad = 0; exp_n = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !error, "R1 handshake outputs in reset", {busy, done, error}, 0);
    check(fl_ce_n && fl_oe_n && fl_we_n, "R1 strobes high in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);

    for (int w = 0; w < 4; w++) begin
      cfg_wait = 3'(w); busy_len = w + 1; stat5 = 0; stuck = 0;
      // program
      a = 22'(w * 22'h0A5173 + 3); d = 8'h5A ^ 8'(w * 51);
      set_exp(0, a, d); run_op(2'd0, a, d, 0, err, rv);
      chk_seq("R2/R3 program write cycles");
      check(width_bad == 0, "R7 strobe width on program", width_bad, 0);
      check(rd_n == 2 * ((busy_len + 1) / 2 + 1), "R8 poll read count", rd_n, 2 * ((busy_len + 1) / 2 + 1));
      check(!err, "R8 program ends without error", err, 0);
      mir[a[5:0]] = mir[a[5:0]] & d;
      check(rv == mir[a[5:0]], "R3 settled byte after program", rv, mir[a[5:0]]);
      // read back
      set_exp(3, a, 0); run_op(2'd3, a, 8'h00, 0, err, rv);
      chk_seq("R6 read makes no write");
      check(rd_n == 1, "R6 single read cycle", rd_n, 1);
      check(rv == mir[a[5:0]], "R6 read data", rv, mir[a[5:0]]);
      check(width_bad == 0, "R7 strobe width on read", width_bad, 0);
      // sector erase
      a = 22'(w * 22'h111111 + 22'h25);
      set_exp(1, a, 0); run_op(2'd1, a, 8'h00, 0, err, rv);
      chk_seq("R2/R4 erase write cycles");
      check(rd_n == 2 * ((busy_len + 1) / 2 + 1), "R4 erase poll read count", rd_n, 2 * ((busy_len + 1) / 2 + 1));
      check(!err && rv == 8'hFF, "R4 erase ends with erased byte", {err, rv}, 8'hFF);
      for (int i = 0; i < 16; i++) mir[{a[5:4], 4'(i)}] = 8'hFF;
      run_op(2'd3, a ^ 22'h9, 8'h00, 0, err, rv);
      check(rv == 8'hFF, "R4 other byte of sector erased", rv, 8'hFF);
      // identify
      a = 22'(w * 22'h2A0005 + w);
      set_exp(2, a, 0); run_op(2'd2, a, 8'h00, 0, err, rv);
      chk_seq("R2/R5 identify write cycles");
      check(rd_n == 1, "R5 identify has one read and no polling", rd_n, 1);
      check(rv == (a[0] ? 8'h4F : 8'h01), "R5 identify value", rv, a[0] ? 8'h4F : 8'h01);
    end

    // status bit 5 set, flash finishes within the extra pair
    cfg_wait = 3'd1; busy_len = 2; stat5 = 1; stuck = 0;
    a = 22'h3C_0012; d = 8'hC3;
    set_exp(0, a, d); run_op(2'd0, a, d, 0, err, rv);
    mir[a[5:0]] = mir[a[5:0]] & d;
    chk_seq("R9 program write cycles");
    check(rd_n == 4, "R9 one extra pair after bit 5", rd_n, 4);
    check(!err && rv == mir[a[5:0]], "R9 recovery without error", {err, rv}, mir[a[5:0]]);

    // flash never settles: reset command and error
    busy_len = 3; stat5 = 1; stuck = 1;
    a = 22'h01_0007; d = 8'h7E;
    set_exp(0, a, d); push(22'h5555, 8'hF0);
    run_op(2'd0, a, d, 0, err, rv);
    mir[a[5:0]] = mir[a[5:0]] & d;
    chk_seq("R10 program then reset command");
    check(rd_n == 4, "R10 two pairs before giving up", rd_n, 4);
    check(err == 1'b1, "R10 error raised with done", err, 1);
    stuck = 0; stat5 = 0;

    // start during an operation is ignored
    busy_len = 3; cfg_wait = 3'd2;
    a = 22'h2B_3338; d = 8'h96;
    set_exp(0, a, d); run_op(2'd0, a, d, 1, err, rv);
    mir[a[5:0]] = mir[a[5:0]] & d;
    repeat (40) @(negedge clk);
    chk_seq("R11 second start adds no cycles");
    check(done_n == 1 && !busy, "R11 no second operation", done_n, 1);
    run_op(2'd3, 22'h00_0030, 8'h00, 0, err, rv);
    check(rv == mir[6'h30], "R11 ignored erase left sector intact", rv, mir[6'h30]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule